// File: doc/BRIEF.md
# Terminal Bell Tone Generator

This block sounds the terminal's bell through a speaker pin. There are two causes. The first is a margin warning while typing: the cursor reaches the thirteenth column of a 20-column block, the line-end flag is set, the keyboard has a character ready, and the sequencer is in the margin phase. The second is a bell control character (0x07) that appears on the write bus during the bell phase.

Either cause starts a retriggerable one-shot timer whose length is a parameter in system clock cycles. The nominal length is about 30 ms. While the timer runs, the serial bit-rate clock is synchronized into the system clock domain and passed to the speaker pin. At all other times the pin stays low. A new trigger while the timer is running reloads the full length.

Top module: `bell_tone_gen`

## Requirements
- R1: A margin bell is qualified only when `col_pos` equals 12, the zero-based thirteenth column of a 20-column block, which leaves seven columns after it. Columns 11 and 13 never qualify.
- R2: A margin bell also needs `eol_flag`, `kbd_avail` and `phase` = 4'hC all true in the same cycle. If any one of them is missing, no bell sounds, so host data alone never causes a margin bell.
- R3: A bell character is qualified when `wr_strobe` is high, `wr_byte` = 8'h07 and `phase` = 4'h2, all in the same cycle. Any other byte, any other phase, or a missing strobe has no effect.
- R4: If a trigger is sampled at clock edge k and `tone_in` is held high, `spk_out` is high after edges k+2 through k+HOLD_CYCLES+1, which is exactly HOLD_CYCLES cycles, and low after that.
- R5: A trigger while the timer is running restarts the full length. A second trigger d cycles after the first gives a high window of d+HOLD_CYCLES cycles.
- R6: While the timer runs, `spk_out` copies `tone_in` with a delay of three cycles: two synchronizer stages and one output register.
- R7: `spk_out` is low while `rst_n` is low. It drops at once when reset is asserted, even in the middle of a tone, and it stays low whenever the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| col_pos | input | 5 | Cursor column within the current 20-column block, zero-based |
| eol_flag | input | 1 | The cursor's line is at its end |
| kbd_avail | input | 1 | The keyboard has a character ready |
| phase | input | 4 | Current sequencer cycle code |
| wr_byte | input | 8 | Byte on the write bus |
| wr_strobe | input | 1 | `wr_byte` is valid in this cycle |
| tone_in | input | 1 | Serial bit-rate clock used as the tone, asynchronous |
| spk_out | output | 1 | Speaker drive |

## Verification
The assertions assume that every qualifier input except `tone_in` is synchronous to `clk`, and that `col_pos` stays within 0 to 19. The bench therefore changes all inputs on the falling edge and holds each trigger for exactly one rising edge. `tone_in` is free to change at any time, because it passes through the synchronizer. The bench keeps `tone_in` low across every reset so that its reference model and the design come out of reset in the same state.

// File: rtl/bell_pkg.sv
package bell_pkg;
  // ASCII bell control character
  localparam logic [7:0] BELL_CHAR = 8'h07;

  typedef logic [7:0] wbyte_t;
endpackage

// File: rtl/bell_trigger.sv
module bell_trigger
  import bell_pkg::*;
#(
  parameter int BLOCK_COLS   = 20,
  parameter int MARGIN_LEAD  = 7,
  parameter int COL_W        = $clog2(BLOCK_COLS),
  parameter int PH_W         = 4,
  parameter logic [3:0] MARGIN_PHASE = 4'hC,
  parameter logic [3:0] BEL_PHASE    = 4'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] col_pos,
  input  logic             eol_flag,
  input  logic             kbd_avail,
  input  logic [PH_W-1:0]  phase,
  input  wbyte_t           wr_byte,
  input  logic             wr_strobe,
  output logic             fire_q
);
  localparam int MARGIN_IDX = BLOCK_COLS - MARGIN_LEAD - 1;

  logic at_margin;
  logic margin_hit;
  logic bel_hit;
  logic fire_d;

  always_comb begin
    at_margin  = (col_pos == COL_W'(MARGIN_IDX));
    margin_hit = at_margin && eol_flag && kbd_avail &&
                 (phase == PH_W'(MARGIN_PHASE));
    bel_hit    = wr_strobe && (wr_byte == BELL_CHAR) &&
                 (phase == PH_W'(BEL_PHASE));
    fire_d     = margin_hit || bel_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_d;
  end
endmodule

// File: rtl/bell_oneshot.sv
module bell_oneshot #(
  parameter int HOLD_CYCLES = 7_500_000,
  parameter int CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = fire || (cnt_q != '0);
    cnt_d  = fire ? HOLD_V : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R5: any trigger reloads the full length
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == HOLD_V));

  // R4: without a trigger the count falls by one per cycle
  a_r4_decay: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4: an idle timer stays idle until a trigger arrives
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/bell_tone_gate.sv
module bell_tone_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tone_in,
  output logic spk_out
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   spk_d;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      assign sync_d[i] = tone_in;
    end else begin : g_rest
      assign sync_d[i] = sync_q[i-1];
    end
  end

  assign spk_d = active && sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      spk_out <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      spk_out <= spk_d;
    end
  end
endmodule

// File: rtl/bell_tone_gen.sv
module bell_tone_gen
  import bell_pkg::*;
#(
  parameter int BLOCK_COLS   = 20,
  parameter int MARGIN_LEAD  = 7,
  parameter int COL_W        = $clog2(BLOCK_COLS),
  parameter int PH_W         = 4,
  parameter logic [3:0] MARGIN_PHASE = 4'hC,
  parameter logic [3:0] BEL_PHASE    = 4'h2,
  parameter int HOLD_CYCLES  = 7_500_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] col_pos,
  input  logic             eol_flag,
  input  logic             kbd_avail,
  input  logic [PH_W-1:0]  phase,
  input  logic [7:0]       wr_byte,
  input  logic             wr_strobe,
  input  logic             tone_in,
  output logic             spk_out
);
  localparam int MARGIN_IDX = BLOCK_COLS - MARGIN_LEAD - 1;

  logic [1:0] rst_pipe;
  logic       rst_s;
  logic       fire_q;
  logic       active;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  bell_trigger #(
    .BLOCK_COLS  (BLOCK_COLS),
    .MARGIN_LEAD (MARGIN_LEAD),
    .COL_W       (COL_W),
    .PH_W        (PH_W),
    .MARGIN_PHASE(MARGIN_PHASE),
    .BEL_PHASE   (BEL_PHASE)
  ) u_trig (
    .clk      (clk),
    .rst_n    (rst_s),
    .col_pos  (col_pos),
    .eol_flag (eol_flag),
    .kbd_avail(kbd_avail),
    .phase    (phase),
    .wr_byte  (wr_byte),
    .wr_strobe(wr_strobe),
    .fire_q   (fire_q)
  );

  bell_oneshot #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_s),
    .fire  (fire_q),
    .active(active)
  );

  bell_tone_gate #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_gate (
    .clk    (clk),
    .rst_n  (rst_s),
    .active (active),
    .tone_in(tone_in),
    .spk_out(spk_out)
  );

  // R1, R2: a fully qualified margin condition raises the trigger
  a_r1_margin_fires: assert property (@(posedge clk) disable iff (!rst_s)
    (col_pos == COL_W'(MARGIN_IDX) && eol_flag && kbd_avail &&
     phase == PH_W'(MARGIN_PHASE)) |=> fire_q);

  // R3: a bell character in the bell phase raises the trigger
  a_r3_bell_fires: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_strobe && wr_byte == BELL_CHAR && phase == PH_W'(BEL_PHASE)) |=> fire_q);

  // R2: with a margin qualifier missing and no bell character, nothing fires
  a_r2_unqualified_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    (!(eol_flag && kbd_avail) && !wr_strobe) |=> !fire_q);

  // R7: an idle timer keeps the speaker low
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_s)
    !active |=> !spk_out);

  // R6: a running timer passes a high tone through
  a_r6_tone_passes: assert property (@(posedge clk) disable iff (!rst_s)
    (active && $past(tone_in, SYNC_STAGES)) |=> spk_out);
endmodule

// File: tb/tb_bell_tone_gen.sv
`timescale 1ns/1ps
module tb_bell_tone_gen;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] col_pos;
  logic       eol_flag, kbd_avail;
  logic [3:0] phase;
  logic [7:0] wr_byte;
  logic       wr_strobe;
  logic       tone_in;
  logic       spk_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R6";
  bit sb_on = 1'b0;
  bit exp_q[$];

  // reference model state
  bit m_trig, m_t1, m_t2;
  int m_cnt;

  always #2 clk = ~clk;

  bell_tone_gen #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .col_pos(col_pos), .eol_flag(eol_flag),
    .kbd_avail(kbd_avail), .phase(phase), .wr_byte(wr_byte),
    .wr_strobe(wr_strobe), .tone_in(tone_in), .spk_out(spk_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver side of the scoreboard: predicts spk_out from R1..R6 and queues it
  always @(posedge clk) begin
    if (sb_on) begin
      bit hit, nspk;
      int ncnt;
      hit  = ((col_pos == 5'd12) && eol_flag && kbd_avail && phase == 4'hC) ||
             (wr_strobe && wr_byte == 8'h07 && phase == 4'h2);
      nspk = (m_cnt != 0) && m_t2;
      ncnt = m_trig ? HOLD : ((m_cnt != 0) ? m_cnt - 1 : 0);
      m_t2 = m_t1; m_t1 = tone_in; m_cnt = ncnt; m_trig = hit;
      exp_q.push_back(nspk);
    end
  end

  // monitor side: compares away from the active edge
  always @(negedge clk) begin
    if (sb_on && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk(spk_out == e, cur_req, int'(spk_out), int'(e));
    end
  end

  task automatic idle_inputs();
    col_pos = 5'd0; eol_flag = 1'b0; kbd_avail = 1'b0; phase = 4'h0;
    wr_byte = 8'h00; wr_strobe = 1'b0;
  endtask

  task automatic sb_start();
    m_trig = 0; m_t1 = 0; m_t2 = 0; m_cnt = 0;
    exp_q.delete();
    sb_on = 1'b1;
  endtask

  // apply one stimulus for a single rising edge
  task automatic pulse(input logic [4:0] c, input bit e, input bit k,
                       input logic [3:0] p, input logic [7:0] b, input bit s);
    @(negedge clk);
    col_pos = c; eol_flag = e; kbd_avail = k; phase = p; wr_byte = b; wr_strobe = s;
    @(negedge clk);
    idle_inputs();
  endtask

  // sample spk_out for n falling edges starting at the current one
  task automatic measure(input int n, output int first, output int highs);
    first = -1; highs = 0;
    for (int i = 0; i < n; i++) begin
      if (spk_out) begin
        highs++;
        if (first < 0) first = i;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_silent(input logic [4:0] c, input bit e, input bit k,
                               input logic [3:0] p, input logic [7:0] b, input bit s,
                               input string req);
    int f, h;
    cur_req = req;
    pulse(c, e, k, p, b, s);
    measure(12, f, h);
    chk(h == 0, req, h, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f, h;
    idle_inputs();
    tone_in = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(spk_out == 1'b0, "R7", int'(spk_out), 0);   // R7 reset state
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1 sb_start();

    // R1, R4: margin bell window with a steady tone
    tone_in = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = "R4";
    pulse(5'd12, 1, 1, 4'hC, 8'h00, 0);
    measure(HOLD + 10, f, h);
    chk(f == 2, "R4", f, 2);
    chk(h == HOLD, "R1", h, HOLD);

    // R1: neighbouring columns never qualify
    expect_silent(5'd11, 1, 1, 4'hC, 8'h00, 0, "R1");
    expect_silent(5'd13, 1, 1, 4'hC, 8'h00, 0, "R1");
    // R2: each margin qualifier missing in turn
    expect_silent(5'd12, 0, 1, 4'hC, 8'h00, 0, "R2");
    expect_silent(5'd12, 1, 0, 4'hC, 8'h00, 0, "R2");
    expect_silent(5'd12, 1, 1, 4'hD, 8'h00, 0, "R2");

    // R3: bell character in the bell phase
    cur_req = "R3";
    pulse(5'd0, 0, 0, 4'h2, 8'h07, 1);
    measure(HOLD + 10, f, h);
    chk(h == HOLD, "R3", h, HOLD);
    expect_silent(5'd0, 0, 0, 4'h2, 8'h47, 1, "R3");
    expect_silent(5'd0, 0, 0, 4'h3, 8'h07, 1, "R3");
    expect_silent(5'd0, 0, 0, 4'h2, 8'h07, 0, "R3");

    // R5: retrigger 20 cycles after the first trigger
    cur_req = "R5";
    pulse(5'd12, 1, 1, 4'hC, 8'h00, 0);
    f = -1; h = 0;
    for (int i = 0; i < HOLD + 40; i++) begin
      if (spk_out) begin
        h++;
        if (f < 0) f = i;
      end
      if (i == 19) begin
        phase = 4'h2; wr_byte = 8'h07; wr_strobe = 1'b1;
      end
      if (i == 20) idle_inputs();
      @(negedge clk);
    end
    chk(f == 2, "R5", f, 2);
    chk(h == HOLD + 20, "R5", h, HOLD + 20);

    // R6: toggling tone during a running timer (scoreboard compares each cycle)
    cur_req = "R6";
    pulse(5'd12, 1, 1, 4'hC, 8'h00, 0);
    h = 0;
    for (int i = 0; i < HOLD; i++) begin
      if (i % 3 == 0) tone_in = ~tone_in;
      if (spk_out) h++;
      @(negedge clk);
    end
    chk(h > 0 && h < HOLD - 4, "R6", h, HOLD / 2);
    tone_in = 1'b1;
    repeat (HOLD + 10) @(negedge clk);

    // R7: reset in the middle of a tone drops the speaker at once
    cur_req = "R7";
    pulse(5'd12, 1, 1, 4'hC, 8'h00, 0);
    repeat (8) @(negedge clk);
    chk(spk_out == 1'b1, "R7", int'(spk_out), 1);
    sb_on = 1'b0;
    tone_in = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    chk(spk_out == 1'b0, "R7", int'(spk_out), 0);
    repeat (3) @(negedge clk);
    chk(spk_out == 1'b0, "R7", int'(spk_out), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1 sb_start();
    cur_req = "R7";
    repeat (HOLD + 5) @(negedge clk);
    chk(spk_out == 1'b0, "R7", int'(spk_out), 0);   // stays low with timer idle

    #1 sb_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule